// File: doc/BRIEF.md
# Dual-Clock Flip-Flop Register File

This block is a small word-addressed memory built entirely from ordinary flip-flops, for places in a chip where a dedicated RAM macro is not available or is too large for the job. One port writes and the other port reads. Each port runs on its own clock, so a producer in one clock domain can fill entries while a consumer in another domain reads them.

Elaboration parameters set the word width, the number of words, the active edge (rising or falling) of each port's clock, and how the read port behaves. In registered mode the addressed word is captured into an output register on the active read edge. In combinational mode the output follows the read address with no read clock involved. Edge choice inverts the clock polarity once at elaboration, so no clock is gated or multiplexed at run time. Stored words are never reset. Only the registered output clears on a synchronous reset in the read domain.

Top module: `rf_dual_port`

## Requirements
- R1: When `wr_en` is 1 on the active write edge and `wr_addr` is below `DEPTH`, `wr_data` is stored at `wr_addr` and is returned by later reads of that address.
- R2: When `wr_en` is 0 on the active write edge, no stored word changes.
- R3: In registered mode, `rd_en` high on the active read edge loads the word at `rd_addr` into `rd_q`, which shows it one read edge after the address is presented.
- R4: In registered mode, `rd_en` low on the active read edge leaves `rd_q` unchanged.
- R5: In registered mode with one clock on both ports, a write and a read of the same address on the same edge returns the word stored before that write.
- R6: In combinational mode, `rd_q` equals the word at `rd_addr` whenever `rd_en` is 1 and is all zeros whenever `rd_en` is 0, with no read clock edge needed.
- R7: A write to an address at or above `DEPTH` changes no stored word (it does not wrap to a lower address), and a read of such an address returns all zeros.
- R8: In registered mode, `rd_rst` high on the active read edge clears `rd_q` to zero, and stored words keep their values through that reset.
- R9: With `WR_EDGE` set to falling, a write takes effect at the falling edge of `wr_clk` and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock; active edge set by `WR_EDGE` |
| wr_en | input | 1 | Active-high write request |
| wr_addr | input | ADDR_W | Word address for writes |
| wr_data | input | WIDTH | Word to be stored |
| rd_clk | input | 1 | Read port clock; active edge set by `RD_EDGE`; unused in combinational mode |
| rd_rst | input | 1 | Active-high synchronous clear of the output register, read domain |
| rd_en | input | 1 | Active-high read request |
| rd_addr | input | ADDR_W | Word address for reads |
| rd_q | output | WIDTH | Read data word |

## Verification
The default depth is twelve, which is not a power of two, so addresses 12 and 15 fit in the address field but name no entry. A design that reduced those addresses modulo the depth would corrupt entries 0 and 3, and a design that skipped the range check on the read side would return undefined data. The bench also runs a same-address write and read on one shared edge, where a design with the write visible to the read would return the new word instead of the old one. It checks that a disabled read keeps the previous output, and that memory survives an output reset. A second instance writes on the falling edge and reads combinationally, and the bench samples it both just before and just after that falling edge to catch a write landing on the wrong edge.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Which clock transition a port acts on.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } clk_edge_e;

    // How the read port presents its data.
    typedef enum logic {
        RD_REGISTERED    = 1'b0,
        RD_COMBINATIONAL = 1'b1
    } rd_mode_e;

    // Address width for a given number of words (at least one bit).
    function automatic int addr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // True when an address names a real entry.
    function automatic logic addr_in_range(input int unsigned addr, input int unsigned depth);
        return addr < depth;
    endfunction

endpackage

// File: rtl/rf_clk_pol.sv
module rf_clk_pol #(
    parameter rf_pkg::clk_edge_e EDGE = rf_pkg::EDGE_RISE
) (
    input  logic clk_in,
    output logic clk_out
);
    // Polarity fixed at elaboration: the active edge becomes a rising edge.
    generate
        if (EDGE == rf_pkg::EDGE_RISE) begin : g_rise
            assign clk_out = clk_in;
        end else begin : g_fall
            assign clk_out = ~clk_in;
        end
    endgenerate
endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int                WIDTH   = 8,
    parameter int                DEPTH   = 12,
    parameter int                ADDR_W  = 4,
    parameter rf_pkg::clk_edge_e WR_EDGE = rf_pkg::EDGE_RISE
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_word,
    output logic              rd_oob
);
    import rf_pkg::*;

    logic [WIDTH-1:0] cells [DEPTH];
    logic             wclk_act;
    logic             wr_ok;

    rf_clk_pol #(.EDGE(WR_EDGE)) u_wpol (
        .clk_in  (wr_clk),
        .clk_out (wclk_act)
    );

    assign wr_ok = wr_en && addr_in_range(32'(wr_addr), DEPTH);

    // Write port: one cell updated per active edge, out-of-range dropped.
    always_ff @(posedge wclk_act) begin
        if (wr_ok) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // Read mux: out-of-range addresses yield zero.
    always_comb begin
        rd_oob  = !addr_in_range(32'(rd_addr), DEPTH);
        rd_word = '0;
        if (!rd_oob) begin
            rd_word = cells[rd_addr];
        end
    end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
    parameter int                WIDTH   = 8,
    parameter rf_pkg::clk_edge_e RD_EDGE = rf_pkg::EDGE_RISE,
    parameter rf_pkg::rd_mode_e  RD_MODE = rf_pkg::RD_REGISTERED
) (
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] word_in,
    input  logic             word_oob,
    output logic [WIDTH-1:0] rd_q
);
    generate
        if (RD_MODE == rf_pkg::RD_REGISTERED) begin : g_reg
            logic             rclk_act;
            logic [WIDTH-1:0] q_r;

            rf_clk_pol #(.EDGE(RD_EDGE)) u_rpol (
                .clk_in  (rd_clk),
                .clk_out (rclk_act)
            );

            always_ff @(posedge rclk_act) begin
                if (rd_rst) begin
                    q_r <= '0;
                end else if (rd_en) begin
                    q_r <= word_in;
                end
            end

            assign rd_q = q_r;

            // R4: disabled read keeps the output register
            assert_hold_on_idle_R4: assert property (@(posedge rclk_act) disable iff (rd_rst)
                !rd_en |=> $stable(q_r));

            // R8: reset in read domain clears the output
            assert_reset_clears_R8: assert property (@(posedge rclk_act)
                rd_rst |=> (q_r == '0));

            // R7: read of a missing entry yields zero
            assert_oob_read_zero_R7: assert property (@(posedge rclk_act) disable iff (rd_rst)
                (rd_en && word_oob) |=> (q_r == '0));
        end else begin : g_comb
            always_comb begin
                rd_q = rd_en ? word_in : '0;
                // R7: combinational read of a missing entry yields zero
                if (rd_en && word_oob) begin
                    assert_oob_comb_zero_R7: assert (rd_q == '0);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rf_dual_port.sv
module rf_dual_port #(
    parameter int                WIDTH   = 8,
    parameter int                DEPTH   = 12,
    parameter rf_pkg::clk_edge_e WR_EDGE = rf_pkg::EDGE_RISE,
    parameter rf_pkg::clk_edge_e RD_EDGE = rf_pkg::EDGE_RISE,
    parameter rf_pkg::rd_mode_e  RD_MODE = rf_pkg::RD_REGISTERED,
    localparam int               ADDR_W  = rf_pkg::addr_bits(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_q
);
    logic [WIDTH-1:0] sel_word;
    logic             sel_oob;

    rf_store #(
        .WIDTH   (WIDTH),
        .DEPTH   (DEPTH),
        .ADDR_W  (ADDR_W),
        .WR_EDGE (WR_EDGE)
    ) u_store (
        .wr_clk  (wr_clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (sel_word),
        .rd_oob  (sel_oob)
    );

    rf_rd_port #(
        .WIDTH   (WIDTH),
        .RD_EDGE (RD_EDGE),
        .RD_MODE (RD_MODE)
    ) u_rport (
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_en    (rd_en),
        .word_in  (sel_word),
        .word_oob (sel_oob),
        .rd_q     (rd_q)
    );
endmodule

// File: tb/tb_rf_dual_port.sv
`timescale 1ns/1ps
module tb_rf_dual_port;
    logic       clk = 1'b0;
    logic       rst;
    logic       we;
    logic [3:0] wa;
    logic [7:0] wd;
    logic       re;
    logic [3:0] ra;
    logic [7:0] q_s;
    logic [7:0] q_c;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk; // 250 MHz

    // Registered read, both ports rising, shared clock.
    rf_dual_port #(.WIDTH(8), .DEPTH(12)) dut (
        .wr_clk(clk), .wr_en(we), .wr_addr(wa), .wr_data(wd),
        .rd_clk(clk), .rd_rst(rst), .rd_en(re), .rd_addr(ra), .rd_q(q_s)
    );

    // Combinational read, write on falling edge.
    rf_dual_port #(.WIDTH(8), .DEPTH(12),
                   .WR_EDGE(rf_pkg::EDGE_FALL),
                   .RD_MODE(rf_pkg::RD_COMBINATIONAL)) dut_comb (
        .wr_clk(clk), .wr_en(we), .wr_addr(wa), .wr_data(wd),
        .rd_clk(clk), .rd_rst(rst), .rd_en(re), .rd_addr(ra), .rd_q(q_c)
    );

    typedef struct packed {
        logic       we;
        logic [3:0] wa;
        logic [7:0] wd;
        logic       re;
        logic [3:0] ra;
        logic [7:0] exp_s;
        logic [7:0] exp_c;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd3,  8'hA5, 1'b0, 4'd0,  8'h00, 8'h00}, // R1 store, R4 idle after reset
        '{1'b1, 4'd5,  8'h3C, 1'b1, 4'd3,  8'hA5, 8'hA5}, // R1 R3 R6
        '{1'b1, 4'd5,  8'h77, 1'b1, 4'd5,  8'h3C, 8'h77}, // R5 old word on shared edge
        '{1'b0, 4'd5,  8'hFF, 1'b1, 4'd5,  8'h77, 8'h77}, // R2
        '{1'b1, 4'd0,  8'h11, 1'b1, 4'd5,  8'h77, 8'h77}, // R2 no FF stored
        '{1'b1, 4'd12, 8'hEE, 1'b1, 4'd0,  8'h11, 8'h11}, // R7 write 12 no wrap
        '{1'b0, 4'd0,  8'h00, 1'b1, 4'd12, 8'h00, 8'h00}, // R7 read 12
        '{1'b1, 4'd15, 8'h99, 1'b1, 4'd0,  8'h11, 8'h11}, // R7 write 15 ignored
        '{1'b0, 4'd0,  8'h00, 1'b1, 4'd3,  8'hA5, 8'hA5}, // R7 entry 3 untouched
        '{1'b0, 4'd0,  8'h00, 1'b0, 4'd5,  8'hA5, 8'h00}, // R4 hold, R6 zero when off
        '{1'b1, 4'd11, 8'h5A, 1'b0, 4'd0,  8'hA5, 8'h00}, // R1 top entry
        '{1'b0, 4'd0,  8'h00, 1'b1, 4'd11, 8'h5A, 8'h5A}  // R3 top entry
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [3:0] a, input logic [7:0] d,
                         input logic r, input logic [3:0] b);
        we = w; wa = a; wd = d; re = r; ra = b;
    endtask

    // Watchdog
    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 4'd0, 8'h00, 1'b0, 4'd0);
        repeat (2) @(posedge clk);
        #1;
        check("R8 reset state", q_s, 8'h00);
        rst = 1'b0;

        // Table walk: drive at posedge+1, check one edge later.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].we, VECS[i].wa, VECS[i].wd, VECS[i].re, VECS[i].ra);
            @(posedge clk);
            #1;
            check($sformatf("R1-table-reg vec %0d", i), q_s, VECS[i].exp_s);
            check($sformatf("R6-table-comb vec %0d", i), q_c, VECS[i].exp_c);
        end

        // R6: comb output follows the address between edges
        drive(1'b0, 4'd0, 8'h00, 1'b1, 4'd3);
        #0.5;
        check("R6 follow addr 3", q_c, 8'hA5);
        ra = 4'd11;
        #0.5;
        check("R6 follow addr 11", q_c, 8'h5A);

        // R9: falling-edge write timing
        @(posedge clk); #1;
        drive(1'b1, 4'd7, 8'h00, 1'b1, 4'd7);
        @(posedge clk); #1;
        drive(1'b1, 4'd7, 8'hC3, 1'b1, 4'd7);
        #0.5;
        check("R9 before falling edge", q_c, 8'h00);
        #1.0;
        check("R9 after falling edge", q_c, 8'hC3);
        @(posedge clk); #1;
        drive(1'b0, 4'd0, 8'h00, 1'b0, 4'd0);

        // R8: reset clears output, memory survives
        @(posedge clk); #1;
        drive(1'b0, 4'd0, 8'h00, 1'b1, 4'd5);
        @(posedge clk); #1;
        check("R3 load before reset", q_s, 8'h77);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R8 reset clears output", q_s, 8'h00);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R8 memory kept after reset", q_s, 8'h77);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule